// File: doc/BRIEF.md
# Translation Lookaside Buffer with Pinned Entries

This block caches translations from virtual page numbers to physical page numbers plus a small attribute field. It holds two fully associative arrays. The main array has 32 slots, and a rotating pointer picks the slot that each new translation replaces. A pinned array has four slots, and those entries are never chosen for replacement. A lookup compares the requested page number against every valid entry in both arrays at once. The registered result appears on the cycle after the request is accepted.

Software cannot write a translation directly. When a lookup misses, the block asks an external page-table walker for the translation and holds off further lookups until the walker answers. A valid answer is stored. An answer flagged as not present is thrown away. Entries only leave the arrays through invalidate commands, which clear either every entry or every entry for one page number.

After reset the array contents are unknown. Nothing can hit and no walk is started until a full invalidate has run once. A global enable turns translation off: with it low, every lookup misses and no walk is made. A second enable allows or blocks page-table walks. With walks blocked, a miss only reports the miss, and the arrays change only through invalidation.

Top module: `pinned_tlb`

## Requirements
- R1: After reset `rsp_valid`=0, `walk_req`=0 and `req_ready`=1. Until the first cycle with `inv_all`=1, every lookup reports a miss and starts no walk.
- R2: A request is accepted when `req_valid`=1 and `req_ready`=1. On the next cycle `rsp_valid`=1 and `rsp_hit` shows whether a valid entry holds that page number. On a hit, `rsp_ppn` and `rsp_attr` carry that entry's stored values. `rsp_valid`=0 on every other cycle.
- R3: While `tlb_en`=0, an accepted lookup gives `rsp_hit`=0 and starts no walk.
- R4: A miss with `tlb_en`=1 and `walk_en`=1 (after the first invalidate-all) raises `walk_req` on the next cycle, with `walk_vpn` equal to the missed page number. `walk_req` and `walk_vpn` hold, and `req_ready` stays 0, until the cycle in which `walk_rsp_valid`=1. The cycle after that, `req_ready` is 1 again.
- R5: With `walk_en`=0 a miss starts no walk and allocates nothing, so repeating the lookup misses again.
- R6: A walk answer with `walk_rsp_ok`=1 that goes to the main array is written into the slot named by the rotating pointer. The pointer then advances by one, wrapping from 31 to 0. After 32 further main allocations, that entry is overwritten. Hits never move the pointer.
- R7: A walk answer with `walk_rsp_ok`=0 stores nothing and leaves the pointer where it is.
- R8: If `lock_alloc`=1 in the cycle of a valid walk answer and a pinned slot is free, the entry goes into the lowest-numbered free pinned slot and the main pointer does not move. Pinned entries survive any number of main allocations. With all four pinned slots valid, the entry goes to the main array instead.
- R9: `inv_addr`=1 clears every entry in both arrays whose page number equals `inv_vpn`, from the next cycle on.
- R10: `inv_all`=1 clears every entry in both arrays in that cycle. A lookup in the same cycle still sees the old contents.
- R11: A walk answer that arrives in a cycle with `inv_all` or `inv_addr` high is discarded: nothing is stored and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tlb_en | input | 1 | Translation enable; low forces misses |
| walk_en | input | 1 | Allows misses to start page-table walks |
| req_valid | input | 1 | Lookup request |
| req_vpn | input | 20 | Virtual page number to look up |
| req_ready | output | 1 | Lookup can be accepted (no walk pending) |
| rsp_valid | output | 1 | Lookup result valid, one cycle after accept |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | 20 | Physical page number on a hit |
| rsp_attr | output | 8 | Attributes on a hit |
| walk_req | output | 1 | Walk request pending toward the walker |
| walk_vpn | output | 20 | Page number the walk is for |
| walk_rsp_valid | input | 1 | Walker answer strobe |
| walk_rsp_ok | input | 1 | Answer holds a present translation |
| walk_rsp_ppn | input | 20 | Physical page number from the walker |
| walk_rsp_attr | input | 8 | Attributes from the walker |
| lock_alloc | input | 1 | Place the answered entry in the pinned array |
| inv_all | input | 1 | Clear all entries |
| inv_addr | input | 1 | Clear entries that match `inv_vpn` |
| inv_vpn | input | 20 | Page number for the targeted clear |

## Verification
The lookup result is registered, so it is due one cycle after the accepting edge. `walk_req` rises on that same edge and falls on the edge where the walker answers. A stored refill or an invalidate takes effect at its edge, so a lookup one cycle later sees the new contents. The bench drives inputs on the falling edge. It advances a behavioural model on each rising edge, then compares every output against that model on the following falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic {
    ST_LOOK = 1'b0,
    ST_WALK = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tlb_entry_bank.sv
module tlb_entry_bank #(
  parameter int N      = 32,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic [VPN_W-1:0]  look_vpn,
  input  logic              clr_all,
  input  logic              clr_one,
  input  logic [VPN_W-1:0]  clr_vpn,
  input  logic [N-1:0]      wr_sel,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [ATTR_W-1:0] wr_attr,
  output logic              hit,
  output logic [PPN_W-1:0]  hit_ppn,
  output logic [ATTR_W-1:0] hit_attr,
  output logic [N-1:0]      valid_vec
);
  logic [VPN_W-1:0]  tag_q  [N];
  logic [PPN_W-1:0]  ppn_q  [N];
  logic [ATTR_W-1:0] attr_q [N];
  logic [N-1:0]      valid_d;
  logic [N-1:0]      valid_en;
  logic [N-1:0]      match;

  // Contents carry no reset: they are undefined until cleared.
  for (genvar i = 0; i < N; i++) begin : g_slot
    assign match[i]    = valid_vec[i] && (tag_q[i] == look_vpn);
    assign valid_en[i] = wr_sel[i] | clr_all | (clr_one && (tag_q[i] == clr_vpn));
    assign valid_d[i]  = wr_sel[i];

    always_ff @(posedge clk) begin
      if (valid_en[i]) valid_vec[i] <= valid_d[i];
    end

    always_ff @(posedge clk) begin
      if (wr_sel[i]) begin
        tag_q[i]  <= wr_vpn;
        ppn_q[i]  <= wr_ppn;
        attr_q[i] <= wr_attr;
      end
    end
  end

  always_comb begin
    hit      = 1'b0;
    hit_ppn  = '0;
    hit_attr = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        hit      = 1'b1;
        hit_ppn  = hit_ppn | ppn_q[i];
        hit_attr = hit_attr | attr_q[i];
      end
    end
  end
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int N = 32,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  logic [W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (adv) ptr_d = (ptr == W'(N-1)) ? '0 : ptr + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_d;
  end

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr)); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (ptr == (($past(ptr) == W'(N-1)) ? W'(0) : $past(ptr) + W'(1)))); // R6
endmodule

// File: rtl/pinned_tlb.sv
module pinned_tlb #(
  parameter int MAIN_N = 32,
  parameter int LOCK_N = 4,
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int ATTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tlb_en,
  input  logic              walk_en,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [PPN_W-1:0]  rsp_ppn,
  output logic [ATTR_W-1:0] rsp_attr,
  output logic              walk_req,
  output logic [VPN_W-1:0]  walk_vpn,
  input  logic              walk_rsp_valid,
  input  logic              walk_rsp_ok,
  input  logic [PPN_W-1:0]  walk_rsp_ppn,
  input  logic [ATTR_W-1:0] walk_rsp_attr,
  input  logic              lock_alloc,
  input  logic              inv_all,
  input  logic              inv_addr,
  input  logic [VPN_W-1:0]  inv_vpn
);
  import tlb_pkg::*;
  localparam int PTR_W = (MAIN_N > 1) ? $clog2(MAIN_N) : 1;

  walk_state_e       state_q, state_d;
  logic              cleaned_q;
  logic [VPN_W-1:0]  walk_vpn_q;
  logic              main_hit, lock_hit, hit_any;
  logic [PPN_W-1:0]  main_ppn, lock_ppn;
  logic [ATTR_W-1:0] main_attr, lock_attr;
  logic [MAIN_N-1:0] main_valid, main_we;
  logic [LOCK_N-1:0] lock_valid, lock_we, lock_free, lock_low;
  logic [PTR_W-1:0]  ptr;
  logic              accept, start_walk, rsp_take, inv_any, fill, to_lock, main_adv;

  tlb_entry_bank #(.N(MAIN_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_main (
    .clk(clk), .look_vpn(req_vpn), .clr_all(inv_all), .clr_one(inv_addr), .clr_vpn(inv_vpn),
    .wr_sel(main_we), .wr_vpn(walk_vpn_q), .wr_ppn(walk_rsp_ppn), .wr_attr(walk_rsp_attr),
    .hit(main_hit), .hit_ppn(main_ppn), .hit_attr(main_attr), .valid_vec(main_valid));

  tlb_entry_bank #(.N(LOCK_N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ATTR_W(ATTR_W)) u_lock (
    .clk(clk), .look_vpn(req_vpn), .clr_all(inv_all), .clr_one(inv_addr), .clr_vpn(inv_vpn),
    .wr_sel(lock_we), .wr_vpn(walk_vpn_q), .wr_ppn(walk_rsp_ppn), .wr_attr(walk_rsp_attr),
    .hit(lock_hit), .hit_ppn(lock_ppn), .hit_attr(lock_attr), .valid_vec(lock_valid));

  tlb_rr_ptr #(.N(MAIN_N)) u_ptr (.clk(clk), .rst_n(rst_n), .adv(main_adv), .ptr(ptr));

  // Control decode
  always_comb begin
    req_ready  = (state_q == ST_LOOK);
    accept     = req_valid && req_ready;
    hit_any    = cleaned_q && tlb_en && (lock_hit || main_hit);
    start_walk = accept && !hit_any && tlb_en && walk_en && cleaned_q;
    rsp_take   = (state_q == ST_WALK) && walk_rsp_valid;
    inv_any    = inv_all || inv_addr;
    fill       = rsp_take && walk_rsp_ok && !inv_any;
    lock_free  = ~lock_valid;
    lock_low   = lock_free & (~lock_free + LOCK_N'(1));
    to_lock    = fill && lock_alloc && (|lock_free);
    lock_we    = to_lock ? lock_low : '0;
    main_adv   = fill && !to_lock;
    main_we    = main_adv ? (MAIN_N'(1) << ptr) : '0;
    state_d    = state_q;
    case (state_q)
      ST_LOOK: if (start_walk) state_d = ST_WALK;
      ST_WALK: if (walk_rsp_valid) state_d = ST_LOOK;
      default: state_d = ST_LOOK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_LOOK;
      cleaned_q <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rsp_valid <= accept;
      rsp_hit   <= accept && hit_any;
      if (inv_all) cleaned_q <= 1'b1;
    end
  end

  // Datapath registers: clock-enabled, no reset
  always_ff @(posedge clk) begin
    if (accept && hit_any) begin
      rsp_ppn  <= lock_hit ? lock_ppn  : main_ppn;
      rsp_attr <= lock_hit ? lock_attr : main_attr;
    end
    if (start_walk) walk_vpn_q <= req_vpn;
  end

  assign walk_req = (state_q == ST_WALK);
  assign walk_vpn = walk_vpn_q;

  AST_NO_HIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !tlb_en) |=> (rsp_valid && !rsp_hit && !walk_req)); // R3
  AST_HIT_AFTER_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> cleaned_q); // R1
  AST_WALK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && !walk_rsp_valid) |=> (walk_req && $stable(walk_vpn) && !req_ready)); // R4
  AST_PIN_FREE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (|lock_we) |-> ((lock_we & lock_valid) == '0)); // R8
  AST_MAIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (|main_we) |=> (|(main_valid & $past(main_we)))); // R6
  AST_DROP_ON_INV: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && inv_any) |=> $stable(ptr)); // R11
endmodule

// File: tb/pinned_tlb_tb_top.sv
`timescale 1ns/1ps
module pinned_tlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tlb_en = 1'b0, walk_en = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_vpn = '0;
  logic        req_ready, rsp_valid, rsp_hit, walk_req;
  logic [19:0] rsp_ppn, walk_vpn;
  logic [7:0]  rsp_attr;
  logic        walk_rsp_valid = 1'b0, walk_rsp_ok = 1'b0;
  logic [19:0] walk_rsp_ppn = '0;
  logic [7:0]  walk_rsp_attr = '0;
  logic        lock_alloc = 1'b0, inv_all = 1'b0, inv_addr = 1'b0;
  logic [19:0] inv_vpn = '0;

  int    checks = 0, failures = 0;
  string phase = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  pinned_tlb dut_i (
    .clk(clk), .rst_n(rst_n), .tlb_en(tlb_en), .walk_en(walk_en),
    .req_valid(req_valid), .req_vpn(req_vpn), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn), .rsp_attr(rsp_attr),
    .walk_req(walk_req), .walk_vpn(walk_vpn), .walk_rsp_valid(walk_rsp_valid),
    .walk_rsp_ok(walk_rsp_ok), .walk_rsp_ppn(walk_rsp_ppn), .walk_rsp_attr(walk_rsp_attr),
    .lock_alloc(lock_alloc), .inv_all(inv_all), .inv_addr(inv_addr), .inv_vpn(inv_vpn));

  // ---------------- behavioural reference model ----------------
  logic [19:0] m_tag [32]; logic [19:0] m_ppn [32]; logic [7:0] m_attr [32]; bit m_v [32];
  logic [19:0] l_tag [4];  logic [19:0] l_ppn [4];  logic [7:0] l_attr [4];  bit l_v [4];
  int          m_ptr;
  bit          e_busy, e_clean, e_rv, e_hit;
  logic [19:0] e_wvpn, e_ppn;
  logic [7:0]  e_attr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ptr = 0; e_busy = 0; e_clean = 0; e_rv = 0; e_hit = 0;
    end else begin
      bit acc, h, lk_done, dropped;
      acc = req_valid && !e_busy;
      h = 0;
      if (acc && tlb_en && e_clean) begin
        for (int i = 0; i < 32; i++)
          if (m_v[i] && m_tag[i] == req_vpn) begin h = 1; e_ppn = m_ppn[i]; e_attr = m_attr[i]; end
        for (int i = 0; i < 4; i++)
          if (l_v[i] && l_tag[i] == req_vpn) begin h = 1; e_ppn = l_ppn[i]; e_attr = l_attr[i]; end
      end
      e_rv = acc; e_hit = h;
      if (e_busy && walk_rsp_valid) begin
        e_busy = 0;
        dropped = inv_all || inv_addr;
        if (walk_rsp_ok && !dropped) begin
          lk_done = 0;
          if (lock_alloc)
            for (int i = 0; i < 4; i++)
              if (!lk_done && !l_v[i]) begin
                l_v[i] = 1; l_tag[i] = e_wvpn; l_ppn[i] = walk_rsp_ppn; l_attr[i] = walk_rsp_attr;
                lk_done = 1;
              end
          if (!lk_done) begin
            m_v[m_ptr] = 1; m_tag[m_ptr] = e_wvpn; m_ppn[m_ptr] = walk_rsp_ppn;
            m_attr[m_ptr] = walk_rsp_attr; m_ptr = (m_ptr + 1) % 32;
          end
        end
      end else if (acc && !h && tlb_en && walk_en && e_clean) begin
        e_busy = 1; e_wvpn = req_vpn;
      end
      if (inv_all) begin
        for (int i = 0; i < 32; i++) m_v[i] = 0;
        for (int i = 0; i < 4; i++) l_v[i] = 0;
        e_clean = 1;
      end
      if (inv_addr) begin
        for (int i = 0; i < 32; i++) if (m_tag[i] == inv_vpn) m_v[i] = 0;
        for (int i = 0; i < 4; i++) if (l_tag[i] == inv_vpn) l_v[i] = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", phase, what, act, exp, $time);
    end
  endtask

  // Compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready === !e_busy, "req_ready", 32'(req_ready), 32'(!e_busy));
      chk(walk_req === e_busy, "walk_req", 32'(walk_req), 32'(e_busy));
      if (e_busy) chk(walk_vpn === e_wvpn, "walk_vpn", 32'(walk_vpn), 32'(e_wvpn));
      chk(rsp_valid === e_rv, "rsp_valid", 32'(rsp_valid), 32'(e_rv));
      chk(rsp_hit === e_hit, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      if (e_hit) begin
        chk(rsp_ppn === e_ppn, "rsp_ppn", 32'(rsp_ppn), 32'(e_ppn));
        chk(rsp_attr === e_attr, "rsp_attr", 32'(rsp_attr), 32'(e_attr));
      end
    end
  end

  function automatic logic [19:0] pp(input logic [19:0] v); return v ^ 20'hA5A5A; endfunction
  function automatic logic [7:0]  at(input logic [19:0] v); return v[7:0] + 8'd1; endfunction

  task automatic lookup(input logic [19:0] v);
    @(negedge clk); req_valid = 1; req_vpn = v;
    @(negedge clk); req_valid = 0;
  endtask

  // Answer a pending walk (if any), optionally with a same-cycle targeted clear
  task automatic reply(input bit ok, input bit lk, input bit inva, input logic [19:0] iv);
    if (walk_req) begin
      walk_rsp_valid = 1; walk_rsp_ok = ok; walk_rsp_ppn = pp(walk_vpn);
      walk_rsp_attr = at(walk_vpn); lock_alloc = lk; inv_addr = inva; inv_vpn = iv;
      @(negedge clk);
      walk_rsp_valid = 0; walk_rsp_ok = 0; lock_alloc = 0; inv_addr = 0;
    end
  endtask

  task automatic refill(input logic [19:0] v, input bit ok, input bit lk);
    lookup(v); reply(ok, lk, 0, '0);
  endtask

  task automatic clear_one(input logic [19:0] v);
    @(negedge clk); inv_addr = 1; inv_vpn = v;
    @(negedge clk); inv_addr = 0;
  endtask

  task automatic clear_all();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset values and no hit/walk before the first clear
    chk(rsp_valid === 0 && walk_req === 0 && req_ready === 1, "reset outputs",
        {29'd0, rsp_valid, walk_req, req_ready}, 32'd1);
    tlb_en = 1; walk_en = 1;
    lookup(20'h00100); lookup(20'h00100);

    phase = "R10"; clear_all();
    phase = "R4";  refill(20'h00100, 1, 0);
    phase = "R2";  lookup(20'h00100); lookup(20'h00200); reply(1, 0, 0, '0); lookup(20'h00200);
    phase = "R3";  tlb_en = 0; lookup(20'h00100); lookup(20'h00300); tlb_en = 1;
    phase = "R5";  walk_en = 0; lookup(20'h00400); lookup(20'h00400); walk_en = 1;
    phase = "R7";  refill(20'h00500, 0, 0); lookup(20'h00500); reply(0, 0, 0, '0);
    phase = "R8";
    for (int i = 0; i < 5; i++) begin refill(20'h0A000 + 20'(i), 1, 1); lookup(20'h0A000 + 20'(i)); end
    phase = "R6";
    for (int i = 0; i < 34; i++) begin
      refill(20'h0B000 + 20'(i), 1, 0);
      lookup(20'h00100);            // hit or miss; hits must not move the pointer
      reply(0, 0, 0, '0);
    end
    for (int i = 0; i < 34; i++) begin lookup(20'h0B000 + 20'(i)); reply(0, 0, 0, '0); end
    phase = "R8";
    for (int i = 0; i < 4; i++) lookup(20'h0A000 + 20'(i));
    phase = "R9";  clear_one(20'h0A001); clear_one(20'h0B020);
    lookup(20'h0A001); reply(0, 0, 0, '0); lookup(20'h0B020); reply(0, 0, 0, '0);
    lookup(20'h0A002); lookup(20'h0B021);
    phase = "R8";  refill(20'h0C000, 1, 1); lookup(20'h0C000);
    phase = "R11"; lookup(20'h0D000); reply(1, 0, 1, 20'h0B021);
    lookup(20'h0D000); reply(0, 0, 0, '0); lookup(20'h0B021); reply(0, 0, 0, '0);
    phase = "R10"; clear_all();
    lookup(20'h0A000); reply(0, 0, 0, '0); lookup(20'h0C000); reply(0, 0, 0, '0);
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    done = 1;
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule